// File: doc/BRIEF.md
# Thread-Tagged Branch Predictor

This block gives a multithreaded instruction fetch stage its next fetch address. The front end presents a fetch PC and a hardware thread number; one cycle later the block answers whether a branch target entry owned by that thread was found, whether the branch is predicted taken, and which address to fetch next. When the branch resolves, the back end reports the branch PC, thread number, outcome and target on a separate update port. Both ports may be used in the same cycle.

Targets are held in a set-associative target table whose entries record the thread that created them, so one thread can never steer another thread's fetch. Direction comes from one table of 2-bit saturating counters shared by all threads. Each counter is selected by XOR-ing low PC bits with the history of resolved outcomes kept separately for each thread. Call-return prediction and repair of speculative history are handled elsewhere.

Top module: `thread_tagged_bpred`

## Requirements
- R1: A synchronous active-high reset clears every target entry to empty, every per-thread history to zero and every direction counter to 1 (weakly not taken); during and right after reset `pr_valid` is 0.
- R2: A lookup presented with `lk_valid` high yields `pr_valid` high exactly one cycle later; in every other cycle `pr_valid`, `pr_hit` and `pr_taken` are 0.
- R3: A lookup hits only when an entry in set `PC[7:2]` is valid, its stored tag equals all remaining PC bits (`PC[31:8]` and `PC[1:0]`), and its stored thread number equals the looking-up thread; an entry made by another thread for the same PC never hits.
- R4: `pr_taken` is 1 only when the lookup hits and its counter is 2 or 3; `pr_next_pc` is the stored target when taken and `PC + 4` otherwise.
- R5: Each update moves the selected counter up by one on a taken outcome and down by one on a not-taken outcome, holding at 3 and at 0.
- R6: The counter is selected by `PC[12:2] XOR H`, where H is the 11-bit history of the thread concerned, and the single counter table is shared by all threads.
- R7: Every update shifts only the updating thread's history left by one with the outcome (1 = taken) entering bit 0; lookups and updates read the history as it stood before that cycle's shift.
- R8: A taken update that misses creates an entry for that PC and thread; a not-taken update that misses creates none; at most one entry matches a given PC and thread.
- R9: A new entry goes into the lowest-numbered empty way of its set; in a full set it replaces the way chosen by a per-set binary-tree pseudo-LRU, in which every node is turned away from the way most recently allocated or hit by an update.
- R10: When a lookup and an update fall in the same cycle, the lookup reports the target entries, counters and history as they were before that update.
- R11: A taken update that hits its entry replaces the stored target with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to predict |
| lk_tid | input | 2 | Thread issuing the fetch |
| pr_valid | output | 1 | Prediction result present (one cycle after lookup) |
| pr_hit | output | 1 | Target entry of this thread found |
| pr_taken | output | 1 | Branch predicted taken |
| pr_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved branch report this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_tid | input | 2 | Thread that executed it |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The lookup port and the training port can act in the same cycle, including on the same PC and thread: the bench presents a lookup of an untracked branch together with its first taken report. The result in that cycle must be a miss with the fall-through address and a direction taken from the pre-update history and counter, while a lookup in the following cycle must hit with the new target. Direction expectations throughout come from a counter and history image the bench keeps from the requirements, so shared counters trained by one thread are judged against another thread's lookups.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // 2-bit saturating direction counter
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_ghr_bank.sv
module bp_ghr_bank #(
  parameter int THREADS = 4,
  parameter int TID_W   = 2,
  parameter int GHR_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sh_en,
  input  logic [TID_W-1:0] sh_tid,
  input  logic             sh_bit,
  input  logic [TID_W-1:0] a_tid,
  output logic [GHR_W-1:0] a_hist,
  input  logic [TID_W-1:0] b_tid,
  output logic [GHR_W-1:0] b_hist
);

  logic [GHR_W-1:0] hist_all [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [GHR_W-1:0] hist_q;
    always_ff @(posedge clk) begin
      if (rst)
        hist_q <= '0;
      else if (sh_en && sh_tid == TID_W'(t))
        hist_q <= {hist_q[GHR_W-2:0], sh_bit};
    end
    assign hist_all[t] = hist_q;
  end

  assign a_hist = hist_all[a_tid];
  assign b_hist = hist_all[b_tid];

endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  // training: read-modify-write through the asynchronous port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
    end
  end

  // prediction: registered read, old data on a same-cycle write
  always_ff @(posedge clk) begin
    if (rd_en) rd_ctr <= tbl[rd_idx];
  end

endmodule

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int SET_W = 6,
  parameter int WAYS  = 4,
  parameter int TID_W = 2,
  parameter int TAG_W = 26,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  // lookup, answered one cycle later
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TID_W-1:0] lk_tid,
  output logic [WAYS-1:0]  hit_vec,
  output logic [TGT_W-1:0] hit_tgt,
  // training
  input  logic             up_en,
  input  logic [SET_W-1:0] up_set,
  input  logic [TAG_W-1:0] up_tag,
  input  logic [TID_W-1:0] up_tid,
  input  logic             up_taken,
  input  logic [TGT_W-1:0] up_tgt
);

  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  // tree walk: node bit 0 sends the victim search left
  function automatic logic [WAY_W-1:0] plru_pick(input logic [NODES-1:0] t);
    int n;
    n = 0;
    for (int l = 0; l < WAY_W; l++) n = 2 * n + 1 + int'(t[n]);
    return WAY_W'(n - NODES);
  endfunction

  function automatic logic [NODES-1:0] plru_touch(input logic [NODES-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    int n;
    r = t;
    n = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[n] = ~w[WAY_W-1-l];
      n = 2 * n + 1 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  logic             valid_q [SETS][WAYS];
  logic [NODES-1:0] plru_q  [SETS];
  logic [TID_W-1:0] tid_mem [SETS][WAYS];
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [TGT_W-1:0] tgt_mem [SETS][WAYS];

  // ---------------- lookup path ----------------
  logic             rd_valid [WAYS];
  logic [TID_W-1:0] rd_tid   [WAYS];
  logic [TAG_W-1:0] rd_tag   [WAYS];
  logic [TGT_W-1:0] rd_tgt   [WAYS];
  logic [TAG_W-1:0] cmp_tag;
  logic [TID_W-1:0] cmp_tid;

  always_ff @(posedge clk) begin
    if (lk_en) begin
      for (int w = 0; w < WAYS; w++) begin
        rd_valid[w] <= valid_q[lk_set][w];
        rd_tid[w]   <= tid_mem[lk_set][w];
        rd_tag[w]   <= tag_mem[lk_set][w];
        rd_tgt[w]   <= tgt_mem[lk_set][w];
      end
      cmp_tag <= lk_tag;
      cmp_tid <= lk_tid;
    end
  end

  always_comb begin
    hit_tgt = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = rd_valid[w] && rd_tag[w] == cmp_tag && rd_tid[w] == cmp_tid;
      if (hit_vec[w]) hit_tgt = hit_tgt | rd_tgt[w];
    end
  end

  // ---------------- training path ----------------
  logic             up_hit, inv_any, do_write, do_touch;
  logic [WAY_W-1:0] up_way, inv_way, wr_way;

  always_comb begin
    up_hit  = 1'b0;
    up_way  = '0;
    inv_any = 1'b0;
    inv_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[up_set][w] && tag_mem[up_set][w] == up_tag &&
          tid_mem[up_set][w] == up_tid) begin
        up_hit = 1'b1;
        up_way = WAY_W'(w);
      end
      if (!valid_q[up_set][w] && !inv_any) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    if (up_hit)       wr_way = up_way;
    else if (inv_any) wr_way = inv_way;
    else              wr_way = plru_pick(plru_q[up_set]);
    do_write = up_en && up_taken;
    do_touch = up_en && (up_hit || up_taken);
  end

  always_ff @(posedge clk) begin
    if (do_write) begin
      tid_mem[up_set][wr_way] <= up_tid;
      tag_mem[up_set][wr_way] <= up_tag;
      tgt_mem[up_set][wr_way] <= up_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        plru_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) valid_q[s][w] <= 1'b0;
      end
    end else begin
      if (do_write) valid_q[up_set][wr_way] <= 1'b1;
      if (do_touch) plru_q[up_set] <= plru_touch(plru_q[up_set], wr_way);
    end
  end

endmodule

// File: rtl/thread_tagged_bpred.sv
module thread_tagged_bpred
  import bp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int THREADS     = 4,
  parameter int BTB_ENTRIES = 256,
  parameter int BTB_WAYS    = 4,
  parameter int PHT_ENTRIES = 2048,
  parameter int ADDR_LSB    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       lk_valid,
  input  logic [PC_W-1:0]            lk_pc,
  input  logic [$clog2(THREADS)-1:0] lk_tid,
  output logic                       pr_valid,
  output logic                       pr_hit,
  output logic                       pr_taken,
  output logic [PC_W-1:0]            pr_next_pc,
  input  logic                       upd_valid,
  input  logic [PC_W-1:0]            upd_pc,
  input  logic [$clog2(THREADS)-1:0] upd_tid,
  input  logic                       upd_taken,
  input  logic [PC_W-1:0]            upd_target
);

  localparam int TID_W       = $clog2(THREADS);
  localparam int SETS        = BTB_ENTRIES / BTB_WAYS;
  localparam int SET_W       = $clog2(SETS);
  localparam int TAG_W       = PC_W - SET_W;
  localparam int IDX_W       = $clog2(PHT_ENTRIES);
  localparam int GHR_W       = IDX_W;
  localparam int INSTR_BYTES = 1 << ADDR_LSB;

  // set index and tag: every PC bit outside the set field is compared
  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_set = lk_pc[ADDR_LSB +: SET_W];
  assign up_set = upd_pc[ADDR_LSB +: SET_W];
  assign lk_tag = {lk_pc[PC_W-1:ADDR_LSB+SET_W], lk_pc[ADDR_LSB-1:0]};
  assign up_tag = {upd_pc[PC_W-1:ADDR_LSB+SET_W], upd_pc[ADDR_LSB-1:0]};

  // per-thread history
  logic [GHR_W-1:0] lk_hist, up_hist;

  bp_ghr_bank #(.THREADS(THREADS), .TID_W(TID_W), .GHR_W(GHR_W)) u_ghr (
    .clk    (clk),
    .rst    (rst),
    .sh_en  (upd_valid),
    .sh_tid (upd_tid),
    .sh_bit (upd_taken),
    .a_tid  (lk_tid),
    .a_hist (lk_hist),
    .b_tid  (upd_tid),
    .b_hist (up_hist)
  );

  // shared direction counters
  logic [IDX_W-1:0] lk_idx, up_idx;
  ctr_t             lk_ctr;
  assign lk_idx = lk_pc[ADDR_LSB +: IDX_W] ^ lk_hist;
  assign up_idx = upd_pc[ADDR_LSB +: IDX_W] ^ up_hist;

  bp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (lk_valid),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (up_idx),
    .wr_taken (upd_taken)
  );

  // thread-tagged target table
  logic [BTB_WAYS-1:0] btb_hit_vec;
  logic [PC_W-1:0]     btb_tgt;

  bp_btb #(
    .SET_W (SET_W),
    .WAYS  (BTB_WAYS),
    .TID_W (TID_W),
    .TAG_W (TAG_W),
    .TGT_W (PC_W)
  ) u_btb (
    .clk      (clk),
    .rst      (rst),
    .lk_en    (lk_valid),
    .lk_set   (lk_set),
    .lk_tag   (lk_tag),
    .lk_tid   (lk_tid),
    .hit_vec  (btb_hit_vec),
    .hit_tgt  (btb_tgt),
    .up_en    (upd_valid),
    .up_set   (up_set),
    .up_tag   (up_tag),
    .up_tid   (upd_tid),
    .up_taken (upd_taken),
    .up_tgt   (upd_target)
  );

  // result stage
  logic            vld_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= lk_valid;
    if (lk_valid) pc_q <= lk_pc;
  end

  assign pr_valid   = vld_q;
  assign pr_hit     = vld_q && (|btb_hit_vec);
  assign pr_taken   = pr_hit && ctr_says_taken(lk_ctr);
  assign pr_next_pc = pr_taken ? btb_tgt : pc_q + PC_W'(INSTR_BYTES);

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int PC_W = 32,
  parameter int WAYS = 4,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic [PC_W-1:0] lk_pc,
  input logic            pr_valid,
  input logic            pr_hit,
  input logic            pr_taken,
  input logic [PC_W-1:0] pr_next_pc,
  input logic [WAYS-1:0] hit_vec
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pr_valid); // R1

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pr_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pr_valid && !pr_hit && !pr_taken); // R2

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    pr_taken |-> pr_hit); // R4

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_taken) |-> pr_next_pc == $past(lk_pc) + PC_W'(STEP)); // R4

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    pr_valid |-> $onehot0(hit_vec)); // R8

endmodule

bind thread_tagged_bpred bp_checker #(
  .PC_W (PC_W),
  .WAYS (BTB_WAYS),
  .STEP (INSTR_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lk_valid   (lk_valid),
  .lk_pc      (lk_pc),
  .pr_valid   (pr_valid),
  .pr_hit     (pr_hit),
  .pr_taken   (pr_taken),
  .pr_next_pc (pr_next_pc),
  .hit_vec    (btb_hit_vec)
);

// File: tb/sim_thread_tagged_bpred.sv
`timescale 1ns/1ps
module sim_thread_tagged_bpred;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [1:0]  lk_tid = '0;
  logic        pr_valid, pr_hit, pr_taken;
  logic [31:0] pr_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [1:0]  upd_tid = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  always #2.5 clk = ~clk;

  thread_tagged_bpred u0 (
    .clk, .rst, .lk_valid, .lk_pc, .lk_tid, .pr_valid, .pr_hit, .pr_taken,
    .pr_next_pc, .upd_valid, .upd_pc, .upd_tid, .upd_taken, .upd_target
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // image of counters and histories, kept from the requirements
  int          sh_pht [2048];
  logic [10:0] sh_ghr [4];

  localparam logic [31:0] PA = 32'h0000_2040, PB = 32'h0000_5004;
  localparam logic [31:0] PC = 32'h0000_3080, PD = 32'h0000_40C0;
  localparam logic [31:0] PE = 32'h0000_6008;
  localparam logic [31:0] TA1 = 32'h0001_0000, TA2 = 32'h0002_2000;
  localparam logic [31:0] TB  = 32'h0003_3300, TD  = 32'h0004_4440;

  function automatic int pidx(input logic [31:0] pc, input logic [10:0] g);
    return int'(pc[12:2] ^ g);
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shadow_update(input logic [31:0] pc, input logic [1:0] tid, input logic tk);
    int i;
    i = pidx(pc, sh_ghr[tid]);
    if (tk && sh_pht[i] < 3) sh_pht[i]++;
    if (!tk && sh_pht[i] > 0) sh_pht[i]--;
    sh_ghr[tid] = {sh_ghr[tid][9:0], tk};
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_update(input logic [31:0] pc, input logic [1:0] tid,
                           input logic tk, input logic [31:0] tgt);
    upd_valid = 1'b1; upd_pc = pc; upd_tid = tid; upd_taken = tk; upd_target = tgt;
    shadow_update(pc, tid, tk);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic zero_hist(input logic [1:0] tid);
    repeat (11) do_update(PC, tid, 1'b0, 32'h0);
  endtask

  task automatic check_lookup(input logic [31:0] pc, input logic [1:0] tid,
                              input logic exp_hit, input logic [31:0] exp_tgt,
                              input string tag);
    logic exp_tk;
    exp_tk = exp_hit && (sh_pht[pidx(pc, sh_ghr[tid])] >= 2);
    lk_valid = 1'b1; lk_pc = pc; lk_tid = tid;
    @(negedge clk);
    lk_valid = 1'b0;
    check_eq({tag, " valid"}, {31'b0, pr_valid}, 32'd1);
    check_eq({tag, " hit"},   {31'b0, pr_hit},   {31'b0, exp_hit});
    check_eq({tag, " taken"}, {31'b0, pr_taken}, {31'b0, exp_tk});
    check_eq({tag, " next"},  pr_next_pc, exp_tk ? exp_tgt : pc + 32'd4);
  endtask

  task automatic t_reset();
    check_eq("R1 idle after reset", {31'b0, pr_valid}, 32'd0);
    check_lookup(PA, 2'd0, 1'b0, 32'h0, "R1 empty table A");
    check_lookup(PB, 2'd3, 1'b0, 32'h0, "R1 empty table B");
    @(negedge clk);
    check_eq("R2 no result without lookup", {29'b0, pr_valid, pr_hit, pr_taken}, 32'd0);
  endtask

  task automatic t_alloc();
    do_update(PA, 2'd0, 1'b1, TA1);
    do_update(PB, 2'd0, 1'b0, 32'h9999_0000);
    check_lookup(PA, 2'd0, 1'b1, TA1, "R8 taken miss allocates / R1 weak init");
    check_lookup(PB, 2'd0, 1'b0, 32'h0, "R8 not-taken miss no entry");
  endtask

  task automatic t_thread();
    check_lookup(PA, 2'd1, 1'b0, 32'h0, "R3 other thread misses");
    do_update(PA, 2'd1, 1'b1, TB);
    check_lookup(PA, 2'd0, 1'b1, TA1, "R3 owner keeps own target");
    check_lookup(PA, 2'd1, 1'b1, TB, "R3 second thread own entry");
  endtask

  task automatic t_train();
    repeat (16) do_update(PA, 2'd0, 1'b1, TA1);
    check_lookup(PA, 2'd0, 1'b1, TA1, "R4/R5 saturated high predicts taken");
    do_update(PA, 2'd0, 1'b1, TA2);
    check_lookup(PA, 2'd0, 1'b1, TA2, "R11 target rewritten");
    zero_hist(2'd0);
    repeat (4) do_update(PA, 2'd0, 1'b0, 32'h0);
    check_lookup(PA, 2'd0, 1'b1, TA2, "R5 saturated low falls through");
    do_update(PA, 2'd0, 1'b1, TA2);
    zero_hist(2'd0);
    do_update(PA, 2'd0, 1'b1, TA2);
    zero_hist(2'd0);
    check_lookup(PA, 2'd0, 1'b1, TA2, "R5/R7 climbs from 0 to 2");
  endtask

  task automatic t_shared();
    zero_hist(2'd1);
    repeat (3) do_update(PA, 2'd1, 1'b0, 32'h0);
    check_lookup(PA, 2'd0, 1'b1, TA2, "R6 counter shared across threads");
    check_lookup(PA, 2'd1, 1'b1, TB, "R7 thread1 history unaffected");
    do_update(PE, 2'd0, 1'b1, 32'h0005_0000);
    check_lookup(PA, 2'd0, 1'b1, TA2, "R6/R7 history XOR selects other counter");
    check_lookup(PE, 2'd0, 1'b1, 32'h0005_0000, "R6 second branch entry");
  endtask

  task automatic t_plru();
    for (int k = 0; k < 4; k++)
      do_update(32'h0001_0014 + 32'(k) * 32'h100, 2'd2, 1'b1, 32'h0070_0000 + 32'(k));
    for (int k = 0; k < 4; k++)
      check_lookup(32'h0001_0014 + 32'(k) * 32'h100, 2'd2, 1'b1,
                   32'h0070_0000 + 32'(k), "R9 empty ways filled");
    // touch way 0; tree then points at way 2 as victim
    do_update(32'h0001_0014, 2'd2, 1'b1, 32'h0070_0000);
    do_update(32'h0001_0414, 2'd2, 1'b1, 32'h0070_0004);
    check_lookup(32'h0001_0214, 2'd2, 1'b0, 32'h0, "R9 pseudo-LRU victim evicted");
    check_lookup(32'h0001_0114, 2'd2, 1'b1, 32'h0070_0001, "R9 way1 kept");
    check_lookup(32'h0001_0014, 2'd2, 1'b1, 32'h0070_0000, "R9 touched way kept");
    check_lookup(32'h0001_0414, 2'd2, 1'b1, 32'h0070_0004, "R9 new entry hits");
  endtask

  task automatic t_same_cycle();
    logic exp_tk;
    exp_tk = 1'b0;
    lk_valid = 1'b1; lk_pc = PD; lk_tid = 2'd3;
    upd_valid = 1'b1; upd_pc = PD; upd_tid = 2'd3; upd_taken = 1'b1; upd_target = TD;
    shadow_update(PD, 2'd3, 1'b1);
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    check_eq("R10 same-cycle lookup sees old table", {30'b0, pr_hit, pr_taken}, {30'b0, 1'b0, exp_tk});
    check_eq("R10 same-cycle next pc", pr_next_pc, PD + 32'd4);
    check_lookup(PD, 2'd3, 1'b1, TD, "R10 following lookup hits");
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) sh_pht[i] = 1;
    for (int t = 0; t < 4; t++) sh_ghr[t] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc();
    t_thread();
    t_train();
    t_shared();
    t_plru();
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

endmodule